// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a free-running up-counter. It has an 8-bit register port. The counter counts from zero up to a programmable modulo value and then wraps. The channel has one 16-bit register and works in one of two modes.

In capture mode, a selected edge on the input pin copies the running count into the channel register. In compare mode, the pin changes when the count equals the channel register. With the overflow drive bit set, each counter wrap drives the pin high and each match drives it low, so the channel produces PWM. A max-duty bit can hold the pin high for whole periods.

The 16-bit channel register is read and written one byte at a time. The block keeps the two bytes of a pair consistent:
- Reading the high byte holds off captures until the low byte has been read.
- Writing the high byte holds off compare events until the low byte has been written.

Top module: `tmr_ccp_chan`

## Requirements
- R1: Register map: offsets 0 control, 1/2 modulo high/low, 3/4 channel high/low, 5/6 counter high/low (read only). Control bits: [1:0] mode, [3:2] edge select, [4] overflow drive, [5] max duty, [6] reads 0, [7] channel flag. After reset the control byte reads 0, the counter reads 0, the modulo reads 0xFFFF and the pin is low. The channel register is undefined after reset.
- R2: Each clock with `cnt_en` high, the counter advances by one. When it equals the modulo value it wraps to 0 instead, and this wrap is the overflow event. With `cnt_en` low, the counter holds.
- R3: Mode 00 is capture mode. The edge select picks which pin edges capture: 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the counter into the channel register once the pin has passed through a two-stage synchronizer.
- R4: A capture or a compare event sets the channel flag. The flag stays set until a control write with bit 7 at 0. A control write with bit 7 at 1 leaves it unchanged.
- R5: In capture mode, a read of channel high locks out captures and their flag until channel low is read. An edge during the lock is lost.
- R6: In a nonzero mode, a compare event occurs on a counting clock whose count equals the channel register. The event acts on the pin by mode: 01 toggles it, 10 drives it low, 11 drives it high.
- R7: In compare mode, a write of channel high suppresses compare events and the flag until channel low is written.
- R8: In compare mode with overflow drive set, every overflow drives the pin high. Mode 10 then gives a pin that is high for channel+1 of every modulo+1 counting clocks. With overflow drive clear, an overflow leaves the pin unchanged.
- R9: When an overflow and a compare event fall on the same clock while overflow drive is set, the overflow wins and the pin goes high.
- R10: In capture mode the pin holds its value and overflow drive has no effect.
- R11: With overflow drive set, the max-duty bit is sampled at each overflow. From that overflow to the next one, the pin stays high. A set or a clear therefore takes effect at the overflow after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Counter advance enable (prescaled tick) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the byte-pair locks) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cap_in | input | 1 | Capture pin, asynchronous |
| cmp_out | output | 1 | Compare/PWM pin |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit bus and two synchronizer stages. It then programs the modulo to 9 through the bus, which makes a full PWM period ten clocks. This short period makes wraps, the overflow-versus-match collision at channel = modulo, and the period-delayed max-duty hand-over cheap to count clock by clock. For capture tests, the bench stops the counter, so each captured value equals a count the bench has set itself.

// File: rtl/tmr_ccp_pkg.sv
// Shared register offsets and mode encoding for the timer channel.
// Assumes a byte-wide register port with at most eight offsets.
package tmr_ccp_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MOD_H = 3'd1;
    localparam logic [ADDR_W-1:0] A_MOD_L = 3'd2;
    localparam logic [ADDR_W-1:0] A_CH_H  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CH_L  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_H = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_L = 3'd6;

    typedef enum logic [1:0] {
        M_CAP = 2'b00,
        M_TGL = 2'b01,
        M_CLR = 2'b10,
        M_SET = 2'b11
    } mode_e;
endpackage

// File: rtl/tmr_cnt.sv
// Modulo up-counter. Advances on en and wraps to zero after reaching modv.
// Also wraps at all-ones, so a modulo written below the current count
// cannot strand it. wrap is high on the clock that performs the wrap.
module tmr_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] modv,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    assign wrap = en && ((cnt == modv) || (cnt == {W{1'b1}}));

    // count register: clear on reset or wrap, else advance on en
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (en)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_edge.sv
// Synchronizes an asynchronous pin and flags the selected edges.
// sel[0] enables rising edges and sel[1] enables falling edges.
// Assumes STAGES >= 1. hit is high for one clock per qualifying edge.
module tmr_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       hit
);
    logic [STAGES:0] sh;
    logic            rise, fall;

    // synchronizer chain plus one history bit for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
    assign hit  = (sel[0] & rise) | (sel[1] & fall);
endmodule

// File: rtl/tmr_pwm_out.sv
// Pin logic for compare mode.
// Overflow drive has priority over a match. A max-duty request is
// latched at each overflow and holds the pin high for the following period.
// In capture mode the pin holds and the latched max duty is cleared.
module tmr_pwm_out
    import tmr_ccp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  tov,
    input  logic  maxd,
    input  logic  wrap,
    input  logic  cmp_evt,
    output logic  pin,
    output logic  maxd_eff
);
    logic cmp_mode;
    assign cmp_mode = (mode != M_CAP);

    // max-duty state: sampled only at overflow, dropped when not in PWM use
    always_ff @(posedge clk) begin
        if (!rst_n)                maxd_eff <= 1'b0;
        else if (!cmp_mode || !tov) maxd_eff <= 1'b0;
        else if (wrap)             maxd_eff <= maxd;
    end

    // pin: overflow first, then max-duty hold, then the match action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (cmp_mode) begin
            if (tov && wrap) begin
                pin <= 1'b1;
            end else if (tov && maxd_eff) begin
                pin <= 1'b1;
            end else if (cmp_evt) begin
                unique case (mode)
                    M_TGL:   pin <= ~pin;
                    M_CLR:   pin <= 1'b0;
                    M_SET:   pin <= 1'b1;
                    default: pin <= pin;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_ccp_chan.sv
// Timer capture/compare channel with a byte-wide register port.
// Holds the control, modulo and channel registers and the byte-pair locks,
// and connects counter, edge detector and pin logic.
// Assumes CNT_W == 2*BUS_W. bus_rd is a one-clock strobe per byte read.
module tmr_ccp_chan
    import tmr_ccp_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               BUS_W       = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] MOD_RST     = {CNT_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cap_in,
    output logic              cmp_out
);
    localparam int LO_W = BUS_W;
    localparam int HI_W = CNT_W - BUS_W;

    mode_e            mode;
    logic [1:0]       edg;
    logic             tov, maxd, flag;
    logic [CNT_W-1:0] mod_q, chan_q, cnt;
    logic             cap_lock, cmp_lock;
    logic             wrap, hit, cap_evt, cmp_evt, maxd_eff;
    logic             wr_ctrl, wr_ch_h, wr_ch_l;
    logic             unused_wbits;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_ch_h = bus_wr && (bus_addr == A_CH_H);
    assign wr_ch_l = bus_wr && (bus_addr == A_CH_L);
    assign unused_wbits = &{1'b0, bus_wdata[BUS_W-1:BUS_W-2]};

    tmr_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .modv(mod_q),
        .cnt(cnt), .wrap(wrap)
    );

    tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .sel(edg), .hit(hit)
    );

    assign cap_evt = (mode == M_CAP) && hit && !cap_lock;
    assign cmp_evt = (mode != M_CAP) && cnt_en && (cnt == chan_q) && !cmp_lock;

    tmr_pwm_out u_out (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tov(tov), .maxd(maxd),
        .wrap(wrap), .cmp_evt(cmp_evt), .pin(cmp_out), .maxd_eff(maxd_eff)
    );

    // control fields: loaded by a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_CAP;
            edg  <= 2'b00;
            tov  <= 1'b0;
            maxd <= 1'b0;
        end else if (wr_ctrl) begin
            mode <= mode_e'(bus_wdata[1:0]);
            edg  <= bus_wdata[3:2];
            tov  <= bus_wdata[4];
            maxd <= bus_wdata[5];
        end
    end

    // channel flag: set by events (events win), cleared by writing 0 to bit 7
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (cap_evt || cmp_evt)         flag <= 1'b1;
        else if (wr_ctrl && !bus_wdata[7])   flag <= 1'b0;
    end

    // modulo register, byte writable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= MOD_RST;
        end else if (bus_wr && (bus_addr == A_MOD_H)) begin
            mod_q[CNT_W-1:LO_W] <= bus_wdata[HI_W-1:0];
        end else if (bus_wr && (bus_addr == A_MOD_L)) begin
            mod_q[LO_W-1:0] <= bus_wdata[LO_W-1:0];
        end
    end

    // channel register: no reset; a capture wins over a bus write
    always_ff @(posedge clk) begin
        if (cap_evt)      chan_q <= cnt;
        else if (wr_ch_h) chan_q[CNT_W-1:LO_W] <= bus_wdata[HI_W-1:0];
        else if (wr_ch_l) chan_q[LO_W-1:0] <= bus_wdata[LO_W-1:0];
    end

    // capture lock: high-byte read in capture mode until the low-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)                                       cap_lock <= 1'b0;
        else if (bus_rd && (bus_addr == A_CH_L))          cap_lock <= 1'b0;
        else if (bus_rd && (bus_addr == A_CH_H) && (mode == M_CAP))
                                                          cap_lock <= 1'b1;
    end

    // compare lock: high-byte write in compare mode until the low-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)                           cmp_lock <= 1'b0;
        else if (wr_ch_l)                     cmp_lock <= 1'b0;
        else if (wr_ch_h && (mode != M_CAP))  cmp_lock <= 1'b1;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata[7:0] = {flag, 1'b0, maxd, tov, edg, mode};
            A_MOD_H: bus_rdata[HI_W-1:0] = mod_q[CNT_W-1:LO_W];
            A_MOD_L: bus_rdata = mod_q[LO_W-1:0];
            A_CH_H:  bus_rdata[HI_W-1:0] = chan_q[CNT_W-1:LO_W];
            A_CH_L:  bus_rdata = chan_q[LO_W-1:0];
            A_CNT_H: bus_rdata[HI_W-1:0] = cnt[CNT_W-1:LO_W];
            A_CNT_L: bus_rdata = cnt[LO_W-1:0];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_ccp_chan_chk.sv
// Checker for the timer channel: temporal properties over the channel's
// ports and internal state. It is bound into every instance of tmr_ccp_chan.
module tmr_ccp_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             cmp_out,
    input logic [1:0]       mode,
    input logic             tov,
    input logic             wrap,
    input logic             maxd_eff,
    input logic             flag,
    input logic             wr_ctrl,
    input logic             wdata7,
    input logic             cap_lock,
    input logic             cmp_lock,
    input logic             chan_wr,
    input logic [CNT_W-1:0] chan_q,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_q
);
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt == mod_q) |=> (cnt == '0)); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_ctrl && !wdata7)) |=> flag); // R4
    AST_CAP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lock && mode == 2'b00 && !chan_wr) |=> $stable(chan_q)); // R5
    AST_CMP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_lock && mode != 2'b00 && !flag) |=> !flag); // R7
    AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && tov && wrap) |=> cmp_out); // R9
    AST_CAP_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> $stable(cmp_out)); // R10
    AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && tov && maxd_eff) |=> cmp_out); // R11
endmodule

bind tmr_ccp_chan tmr_ccp_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cmp_out(cmp_out),
    .mode(mode), .tov(tov), .wrap(wrap), .maxd_eff(maxd_eff), .flag(flag),
    .wr_ctrl(wr_ctrl), .wdata7(bus_wdata[7]), .cap_lock(cap_lock),
    .cmp_lock(cmp_lock), .chan_wr(wr_ch_h || wr_ch_l), .chan_q(chan_q),
    .cnt(cnt), .mod_q(mod_q)
);

// File: tb/tmr_ccp_chan_tb.sv
// Directed bench for tmr_ccp_chan: one task per scenario.
module tmr_ccp_chan_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       cmp_out;

    int n_chk = 0;
    int n_err = 0;

    tmr_ccp_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [2:0] a_hi, output int v);
        logic [7:0] h, l;
        rd(a_hi, h);
        rd(a_hi + 3'd1, l);
        v = {16'h0, h, l};
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        cnt_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmp_out) hi++;
        end
        cnt_en = 1'b0;
    endtask

    task automatic pin_edge(input logic v);
        cap_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d; int v;
        do_reset();
        rd(3'd0, d);      check("R1 ctrl after reset", d, 8'h00);
        rd16(3'd1, v);    check("R1 modulo after reset", v, 16'hFFFF);
        rd16(3'd5, v);    check("R1 counter after reset", v, 0);
        check("R1 pin after reset", cmp_out, 0);
    endtask

    task automatic t_counter();
        int v;
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        run(23);
        rd16(3'd5, v);    check("R2 count wraps at modulo", v, 3);
        repeat (4) @(negedge clk);
        rd16(3'd5, v);    check("R2 count holds without enable", v, 3);
    endtask

    task automatic t_capture();
        logic [7:0] d; int v;
        do_reset();
        run(37);
        wr(3'd0, 8'h04);
        pin_edge(1'b1);
        rd(3'd0, d);      check("R4 flag set by capture", d, 8'h84);
        rd16(3'd3, v);    check("R3 rising capture", v, 37);
        wr(3'd0, 8'h04);
        run(5);
        pin_edge(1'b0);
        rd(3'd0, d);      check("R3 falling ignored with rise select", d, 8'h04);
        rd16(3'd3, v);    check("R3 value kept on ignored edge", v, 37);
        wr(3'd0, 8'h08);
        pin_edge(1'b1);
        rd(3'd0, d);      check("R3 rising ignored with fall select", d, 8'h08);
        pin_edge(1'b0);
        rd16(3'd3, v);    check("R3 falling capture", v, 42);
        rd(3'd0, d);      check("R4 flag after falling capture", d, 8'h88);
        wr(3'd0, 8'h0C);
        run(3);
        pin_edge(1'b1);
        rd16(3'd3, v);    check("R3 both-edge capture", v, 45);
        wr(3'd0, 8'h00);
        run(2);
        pin_edge(1'b0);
        rd(3'd0, d);      check("R3 no capture with select 00", d, 8'h00);
        rd16(3'd3, v);    check("R3 value kept with select 00", v, 45);
    endtask

    task automatic t_capture_lock();
        logic [7:0] d; int v;
        wr(3'd0, 8'h0C);
        rd(3'd3, d);      check("R5 high byte read", d, 8'h00);
        run(10);
        pin_edge(1'b1);
        rd(3'd0, d);      check("R5 no flag while locked", d, 8'h0C);
        rd(3'd4, d);      check("R5 low byte unchanged by locked edge", d, 8'h2D);
        pin_edge(1'b0);
        rd16(3'd3, v);    check("R5 capture resumes after low read", v, 57);
        rd(3'd0, d);      check("R5 flag after unlock", d, 8'h8C);
    endtask

    task automatic t_compare();
        logic [7:0] d;
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        wr(3'd3, 8'h00); wr(3'd4, 8'h04);
        wr(3'd0, 8'h01);
        run(3);
        check("R6 no event before match", cmp_out, 0);
        rd(3'd0, d);      check("R6 no flag before match", d, 8'h01);
        run(2);
        check("R6 toggle on match", cmp_out, 1);
        rd(3'd0, d);      check("R4 flag set by compare", d, 8'h81);
        run(3);
        rd(3'd0, d);      check("R4 flag sticky", d, 8'h81);
        wr(3'd0, 8'h81);
        rd(3'd0, d);      check("R4 write 1 keeps flag", d, 8'h81);
        wr(3'd0, 8'h01);
        rd(3'd0, d);      check("R4 write 0 clears flag", d, 8'h01);
        run(6);
        check("R8 overflow without drive leaves pin", cmp_out, 1);
        run(1);
        check("R6 second toggle", cmp_out, 0);
        wr(3'd0, 8'h03);
        run(10);
        check("R6 set on match", cmp_out, 1);
        wr(3'd0, 8'h02);
        run(10);
        check("R6 clear on match", cmp_out, 0);
    endtask

    task automatic t_pwm();
        int h;
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        wr(3'd3, 8'h00); wr(3'd4, 8'h03);
        wr(3'd0, 8'h12);
        run(10);
        check("R8 overflow drives pin high", cmp_out, 1);
        count_high(20, h); check("R8 PWM high clocks", h, 8);
        wr(3'd4, 8'h09);
        count_high(20, h); check("R9 overflow beats match", h, 20);
        wr(3'd0, 8'h02);
        count_high(20, h); check("R8 no overflow drive", h, 9);
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        wr(3'd0, 8'h10);
        count_high(25, h); check("R10 overflow drive ignored in capture", h, 0);
    endtask

    task automatic t_max_duty();
        int h;
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        wr(3'd3, 8'h00); wr(3'd4, 8'h03);
        wr(3'd0, 8'h12);
        run(10);
        wr(3'd0, 8'h32);
        count_high(10, h); check("R11 set waits for overflow", h, 4);
        count_high(10, h); check("R11 full duty period", h, 10);
        wr(3'd0, 8'h12);
        count_high(10, h); check("R11 clear waits for overflow", h, 10);
        count_high(10, h); check("R11 normal duty restored", h, 4);
    endtask

    task automatic t_compare_lock();
        logic [7:0] d; int h;
        do_reset();
        wr(3'd1, 8'h00); wr(3'd2, 8'h09);
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h03);
        wr(3'd3, 8'h00);
        count_high(20, h); check("R7 no compare while locked", h, 0);
        rd(3'd0, d);      check("R7 no flag while locked", d, 8'h01);
        wr(3'd4, 8'h03);
        run(10);
        check("R7 compare after low write", cmp_out, 1);
        rd(3'd0, d);      check("R7 flag after unlock", d, 8'h81);
    endtask

    initial begin
        t_reset_state();
        t_counter();
        t_capture();
        t_capture_lock();
        t_compare();
        t_pwm();
        t_max_duty();
        t_compare_lock();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule